// File: doc/BRIEF.md
# Group-1 Interrupt Enable Register Access Gate

This block sits behind the system-register access path of a processor core and owns the enable bit for group-1 interrupts. A register access (read or write, issuing exception level 0 to 3, 16-bit system-register encoding, 64-bit write data) is captured together with a snapshot of every configuration and control bit that governs it. One cycle later the block reports a single verdict: undefined instruction, trap to EL1, EL2 or EL3 with its exception class, redirection to the virtual copy of the register, or a completed access to one physical copy of the enable bit.

When EL3 exists the enable bit is kept as two copies: one for the Secure state and one for the Non-secure state. The effective non-secure control picks the copy. Without EL3 a third, unbanked copy is used. The Secure and Non-secure copies can also be read and written through a 2-bit alias port that stands for the matching bits of the EL3-level group-enable register. Writes through either path are visible through the other.

Top module: `grp1_enable_gate`

## Requirements
- R1: A request gives a result only when its encoding is {op0,op1,CRn,CRm,op2} = {2'b11,3'b000,4'b1100,4'b1100,3'b111} (16'hC667). Any other encoding leaves res_valid low in the following cycle. Reads and writes use the same encoding.
- R2: If the interrupt-controller feature input or the 64-bit-state feature input is 0, or the request comes from EL0, the result is undefined (res_kind = 4'b0001).
- R3: At EL1 the first matching check wins, in this order. (1) EL3 present, debug-undefined-priority set and EL3 IRQ routing set gives undefined. (2) EL1 SRE = 0 traps to EL1. (3) EL2 enabled, fine-grained traps present, EL3 fine-grained enable set (or EL3 absent), and the read trap bit (for a read) or write trap bit (for a write) set, traps to EL2. (4) EL2 enabled with trap-all-group-1 set traps to EL2. (5) EL2 enabled with hypervisor IRQ override set gives the virtual redirect (4'b0100). (6) EL3 present with IRQ routing set gives undefined if debug-undefined is set, and a trap to EL3 otherwise. (7) Anything else is a bank access (4'b1000).
- R4: At EL2 the order is: the debug-undefined-priority check of R3 (1); EL2 SRE = 0 traps to EL2; the EL3 routing check of R3 (6); then a bank access. No fine-grained, trap-all or virtual checks apply at EL2.
- R5: At EL3, an EL3 SRE of 0 traps to EL3 and otherwise the access goes to a bank. An EL3 request while EL3 is absent is undefined.
- R6: A result appears in the cycle after the request is captured, and res_kind is one-hot whenever res_valid is high. A trap (4'b0010) reports res_ec = 6'h18 and res_trap_el = 1, 2 or 3.
- R7: On a bank access res_bank is 0 (unbanked) when EL3 is absent. When EL3 is present it is 1 (Secure) if the effective non-secure control is 0 and 2 (Non-secure) if it is 1.
- R8: A bank read returns the selected enable bit in res_rdata[0] with bits 63:1 zero. A write stores only write-data bit 0. res_rdata is zero for every other result.
- R9: Synchronous reset clears all three enable copies to 0.
- R10: alias_rdata[0] is the Secure copy and alias_rdata[1] the Non-secure copy. alias_we loads both copies from alias_wdata on the next edge. A bank write through the access path updates the alias view on the same edge. If both write the same copy on one edge, the access-path write wins.
- R11: Enable copies change only on a completed bank write or an alias write. Reads, traps, undefined results and virtual redirects leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_el | input | 2 | Issuing exception level |
| req_sysreg | input | 16 | {op0,op1,CRn,CRm,op2} encoding |
| req_wdata | input | 64 | Write data |
| cfg_gic_present | input | 1 | Interrupt-controller system interface implemented |
| cfg_aa64_present | input | 1 | 64-bit execution state implemented |
| cfg_el3_present | input | 1 | EL3 implemented |
| cfg_el2_enabled | input | 1 | EL2 enabled in the current security state |
| cfg_fgt_present | input | 1 | Fine-grained traps implemented |
| ctl_dbg_undef_prio | input | 1 | Debug-undefined takes priority over routing |
| ctl_dbg_undef | input | 1 | Debug-undefined condition active |
| ctl_el3_irq_route | input | 1 | EL3 IRQ routing bit |
| ctl_el3_fgt_en | input | 1 | EL3 fine-grained trap enable |
| ctl_el3_ns | input | 1 | Effective non-secure state |
| ctl_el1_sre | input | 1 | EL1 system-register interface enable |
| ctl_el2_sre | input | 1 | EL2 system-register interface enable |
| ctl_el3_sre | input | 1 | EL3 system-register interface enable |
| ctl_fgt_rd_trap | input | 1 | Fine-grained read trap bit |
| ctl_fgt_wr_trap | input | 1 | Fine-grained write trap bit |
| ctl_trap_all_g1 | input | 1 | Trap all group-1 accesses to EL2 |
| ctl_hyp_irq_override | input | 1 | Hypervisor IRQ override (virtual redirect) |
| alias_we | input | 1 | Write both banked copies through the alias view |
| alias_wdata | input | 2 | {Non-secure, Secure} alias write value |
| alias_rdata | output | 2 | {Non-secure, Secure} current copies |
| res_valid | output | 1 | Verdict present |
| res_write | output | 1 | Verdict belongs to a write |
| res_kind | output | 4 | One-hot: bit0 undefined, bit1 trap, bit2 virtual, bit3 bank |
| res_trap_el | output | 2 | Trap target level |
| res_ec | output | 6 | Exception class of a trap |
| res_bank | output | 2 | 0 unbanked, 1 Secure, 2 Non-secure |
| res_rdata | output | 64 | Bank read data |

## Verification
The checker watches, on every cycle, that verdicts are one-hot, that traps carry class 0x18 and a real target, that EL0, foreign-encoding and EL3-disabled requests get the right verdict, that read data never has upper bits, and that the alias view only moves after a write. The full priority order of each level, the bank choice, and the interplay of alias writes with access-path writes (including a collision on one edge) can only be shown by the bench's sweep of control combinations against its reference model.

// File: rtl/grp1_gate_pkg.sv
package grp1_gate_pkg;

    localparam int REG_BITS = 64;
    localparam int ENC_BITS = 16;
    localparam int EC_BITS  = 6;
    localparam int N_COPIES = 3;

    // {op0, op1, CRn, CRm, op2}
    localparam logic [ENC_BITS-1:0] SYSREG_ENC = {2'b11, 3'b000, 4'b1100, 4'b1100, 3'b111};
    localparam logic [EC_BITS-1:0]  EC_SYSREG  = 6'h18;

    typedef enum logic [1:0] {
        COPY_SOLO = 2'd0,
        COPY_SEC  = 2'd1,
        COPY_NSEC = 2'd2
    } copy_e;

    typedef enum logic [3:0] {
        OUT_NONE  = 4'b0000,
        OUT_UNDEF = 4'b0001,
        OUT_TRAP  = 4'b0010,
        OUT_VIRT  = 4'b0100,
        OUT_BANK  = 4'b1000
    } outcome_e;

    typedef struct packed {
        logic gic;
        logic aa64;
        logic el3;
        logic el2en;
        logic fgt;
        logic dprio;
        logic dundef;
        logic irq_route;
        logic fgt_en;
        logic ns;
        logic sre1;
        logic sre2;
        logic sre3;
        logic fgt_rd;
        logic fgt_wr;
        logic tall1;
        logic imo;
    } ctl_t;

    typedef struct packed {
        logic       valid;
        logic       write;
        logic [1:0] el;
        logic       wbit;
    } req_t;

    typedef struct packed {
        outcome_e   kind;
        logic [1:0] trap_el;
        copy_e      copy;
    } verdict_t;

    function automatic verdict_t make_verdict(outcome_e k, logic [1:0] tel, copy_e c);
        verdict_t v;
        v.kind    = k;
        v.trap_el = tel;
        v.copy    = c;
        return v;
    endfunction

    function automatic copy_e pick_copy(ctl_t c);
        if (!c.el3)
            return COPY_SOLO;
        return c.ns ? COPY_NSEC : COPY_SEC;
    endfunction

    // EL3 routing exit: undefined under debug-undefined, else trap to EL3
    function automatic verdict_t route_exit(ctl_t c);
        if (c.dundef)
            return make_verdict(OUT_UNDEF, 2'd0, COPY_SOLO);
        return make_verdict(OUT_TRAP, 2'd3, COPY_SOLO);
    endfunction

endpackage

// File: rtl/gate_req_stage.sv
module gate_req_stage
    import grp1_gate_pkg::*;
#(
    parameter int DATA_W = REG_BITS,
    parameter int ENC_W  = ENC_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_write,
    input  logic [1:0]        in_el,
    input  logic [ENC_W-1:0]  in_enc,
    input  logic [DATA_W-1:0] in_wdata,
    input  ctl_t              in_ctl,
    output req_t              q_req,
    output ctl_t              q_ctl
);

    localparam logic [ENC_W-1:0] MATCH = ENC_W'(SYSREG_ENC);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^in_wdata[DATA_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            q_req <= '0;
            q_ctl <= '0;
        end else begin
            q_req.valid <= in_valid && (in_enc == MATCH);
            q_req.write <= in_write;
            q_req.el    <= in_el;
            q_req.wbit  <= in_wdata[0];
            q_ctl       <= in_ctl;
        end
    end

endmodule

// File: rtl/gate_perm_chain.sv
module gate_perm_chain
    import grp1_gate_pkg::*;
(
    input  logic       is_write,
    input  logic [1:0] el,
    input  ctl_t       c,
    output verdict_t   verdict
);

    verdict_t v_el1, v_el2, v_el3;
    copy_e    tgt;
    logic     feat_ok;
    logic     dbg_block;
    logic     fgt_hit;

    assign tgt       = pick_copy(c);
    assign feat_ok   = c.gic && c.aa64;
    assign dbg_block = c.el3 && c.dprio && c.irq_route;
    assign fgt_hit   = c.el2en && c.fgt && (!c.el3 || c.fgt_en)
                       && (is_write ? c.fgt_wr : c.fgt_rd);

    // Each level's chain is evaluated in parallel, then selected by level.
    always_comb begin
        if (dbg_block)
            v_el1 = make_verdict(OUT_UNDEF, 2'd0, COPY_SOLO);
        else if (!c.sre1)
            v_el1 = make_verdict(OUT_TRAP, 2'd1, COPY_SOLO);
        else if (fgt_hit)
            v_el1 = make_verdict(OUT_TRAP, 2'd2, COPY_SOLO);
        else if (c.el2en && c.tall1)
            v_el1 = make_verdict(OUT_TRAP, 2'd2, COPY_SOLO);
        else if (c.el2en && c.imo)
            v_el1 = make_verdict(OUT_VIRT, 2'd0, COPY_SOLO);
        else if (c.el3 && c.irq_route)
            v_el1 = route_exit(c);
        else
            v_el1 = make_verdict(OUT_BANK, 2'd0, tgt);
    end

    always_comb begin
        if (dbg_block)
            v_el2 = make_verdict(OUT_UNDEF, 2'd0, COPY_SOLO);
        else if (!c.sre2)
            v_el2 = make_verdict(OUT_TRAP, 2'd2, COPY_SOLO);
        else if (c.el3 && c.irq_route)
            v_el2 = route_exit(c);
        else
            v_el2 = make_verdict(OUT_BANK, 2'd0, tgt);
    end

    always_comb begin
        if (!c.el3)
            v_el3 = make_verdict(OUT_UNDEF, 2'd0, COPY_SOLO);
        else if (!c.sre3)
            v_el3 = make_verdict(OUT_TRAP, 2'd3, COPY_SOLO);
        else
            v_el3 = make_verdict(OUT_BANK, 2'd0, tgt);
    end

    always_comb begin
        if (!feat_ok) begin
            verdict = make_verdict(OUT_UNDEF, 2'd0, COPY_SOLO);
        end else begin
            unique case (el)
                2'd1:    verdict = v_el1;
                2'd2:    verdict = v_el2;
                2'd3:    verdict = v_el3;
                default: verdict = make_verdict(OUT_UNDEF, 2'd0, COPY_SOLO);
            endcase
        end
    end

endmodule

// File: rtl/gate_enable_banks.sv
module gate_enable_banks
    import grp1_gate_pkg::*;
#(
    parameter int NCOPY = N_COPIES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_we,
    input  copy_e            acc_copy,
    input  logic             acc_bit,
    input  logic             alias_we,
    input  logic [NCOPY-2:0] alias_wdata,
    output logic [NCOPY-1:0] bits
);

    for (genvar i = 0; i < NCOPY; i++) begin : g_copy
        localparam logic [1:0] MY_ID   = 2'(i);
        localparam bit         ALIASED = (i != 0);
        localparam int         AIX     = (i == 0) ? 0 : i - 1;

        logic q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (acc_we && (acc_copy == copy_e'(MY_ID)))
                q <= acc_bit;
            else if (ALIASED && alias_we)
                q <= alias_wdata[AIX];
        end

        assign bits[i] = q;
    end

endmodule

// File: rtl/grp1_enable_gate.sv
module grp1_enable_gate
    import grp1_gate_pkg::*;
#(
    parameter int DATA_W = REG_BITS,
    parameter int ENC_W  = ENC_BITS,
    parameter int EC_W   = EC_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_el,
    input  logic [ENC_W-1:0]  req_sysreg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_gic_present,
    input  logic              cfg_aa64_present,
    input  logic              cfg_el3_present,
    input  logic              cfg_el2_enabled,
    input  logic              cfg_fgt_present,
    input  logic              ctl_dbg_undef_prio,
    input  logic              ctl_dbg_undef,
    input  logic              ctl_el3_irq_route,
    input  logic              ctl_el3_fgt_en,
    input  logic              ctl_el3_ns,
    input  logic              ctl_el1_sre,
    input  logic              ctl_el2_sre,
    input  logic              ctl_el3_sre,
    input  logic              ctl_fgt_rd_trap,
    input  logic              ctl_fgt_wr_trap,
    input  logic              ctl_trap_all_g1,
    input  logic              ctl_hyp_irq_override,
    input  logic              alias_we,
    input  logic [1:0]        alias_wdata,
    output logic [1:0]        alias_rdata,
    output logic              res_valid,
    output logic              res_write,
    output logic [3:0]        res_kind,
    output logic [1:0]        res_trap_el,
    output logic [EC_W-1:0]   res_ec,
    output logic [1:0]        res_bank,
    output logic [DATA_W-1:0] res_rdata
);

    localparam int NCOPY = N_COPIES;

    ctl_t             ctl_in;
    ctl_t             ctl_q;
    req_t             req_q;
    verdict_t         verdict;
    logic [NCOPY-1:0] copies;
    logic             is_bank;
    logic             bank_we;

    always_comb begin
        ctl_in.gic       = cfg_gic_present;
        ctl_in.aa64      = cfg_aa64_present;
        ctl_in.el3       = cfg_el3_present;
        ctl_in.el2en     = cfg_el2_enabled;
        ctl_in.fgt       = cfg_fgt_present;
        ctl_in.dprio     = ctl_dbg_undef_prio;
        ctl_in.dundef    = ctl_dbg_undef;
        ctl_in.irq_route = ctl_el3_irq_route;
        ctl_in.fgt_en    = ctl_el3_fgt_en;
        ctl_in.ns        = ctl_el3_ns;
        ctl_in.sre1      = ctl_el1_sre;
        ctl_in.sre2      = ctl_el2_sre;
        ctl_in.sre3      = ctl_el3_sre;
        ctl_in.fgt_rd    = ctl_fgt_rd_trap;
        ctl_in.fgt_wr    = ctl_fgt_wr_trap;
        ctl_in.tall1     = ctl_trap_all_g1;
        ctl_in.imo       = ctl_hyp_irq_override;
    end

    gate_req_stage #(
        .DATA_W (DATA_W),
        .ENC_W  (ENC_W)
    ) u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_write (req_write),
        .in_el    (req_el),
        .in_enc   (req_sysreg),
        .in_wdata (req_wdata),
        .in_ctl   (ctl_in),
        .q_req    (req_q),
        .q_ctl    (ctl_q)
    );

    gate_perm_chain u_chain (
        .is_write (req_q.write),
        .el       (req_q.el),
        .c        (ctl_q),
        .verdict  (verdict)
    );

    assign is_bank = req_q.valid && (verdict.kind == OUT_BANK);
    assign bank_we = is_bank && req_q.write;

    gate_enable_banks #(
        .NCOPY (NCOPY)
    ) u_banks (
        .clk         (clk),
        .rst         (rst),
        .acc_we      (bank_we),
        .acc_copy    (verdict.copy),
        .acc_bit     (req_q.wbit),
        .alias_we    (alias_we),
        .alias_wdata (alias_wdata),
        .bits        (copies)
    );

    assign alias_rdata = copies[2:1];
    assign res_valid   = req_q.valid;
    assign res_write   = req_q.valid && req_q.write;
    assign res_kind    = req_q.valid ? verdict.kind : OUT_NONE;
    assign res_trap_el = (req_q.valid && verdict.kind == OUT_TRAP) ? verdict.trap_el : 2'd0;
    assign res_ec      = (req_q.valid && verdict.kind == OUT_TRAP) ? EC_W'(EC_SYSREG) : '0;
    assign res_bank    = is_bank ? verdict.copy : 2'd0;
    assign res_rdata   = (is_bank && !req_q.write)
                         ? {{(DATA_W-1){1'b0}}, copies[verdict.copy]} : '0;

endmodule

// File: rtl/grp1_enable_gate_chk.sv
module grp1_enable_gate_chk
    import grp1_gate_pkg::*;
#(
    parameter int DATA_W = REG_BITS,
    parameter int ENC_W  = ENC_BITS,
    parameter int EC_W   = EC_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_el,
    input logic [ENC_W-1:0]  req_sysreg,
    input logic              cfg_gic_present,
    input logic              cfg_aa64_present,
    input logic              cfg_el3_present,
    input logic              ctl_el3_sre,
    input logic              alias_we,
    input logic [1:0]        alias_rdata,
    input logic              res_valid,
    input logic              res_write,
    input logic [3:0]        res_kind,
    input logic [1:0]        res_trap_el,
    input logic [EC_W-1:0]   res_ec,
    input logic [DATA_W-1:0] res_rdata
);

    localparam logic [ENC_W-1:0] MATCH = ENC_W'(SYSREG_ENC);

    logic hit_now;
    assign hit_now = req_valid && (req_sysreg == MATCH);

    // R1: a foreign encoding produces no verdict
    p_foreign_enc_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid && req_sysreg != MATCH)) |-> !res_valid);

    // R2: EL0 requests are undefined
    p_el0_undef_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit_now && req_el == 2'd0)) |-> (res_valid && res_kind == 4'b0001));

    // R5: EL3 with interface disabled traps to EL3
    p_el3_sre_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit_now && req_el == 2'd3 && cfg_gic_present && cfg_aa64_present
                               && cfg_el3_present && !ctl_el3_sre))
        |-> (res_kind == 4'b0010 && res_trap_el == 2'd3));

    // R6: one-hot verdict
    p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $onehot(res_kind));

    // R6: trap class and target
    p_trap_ec_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 4'b0010) |-> (res_ec == EC_W'(EC_SYSREG) && res_trap_el != 2'd0));

    // R8: upper read bits are zero
    p_rdata_hi_r8: assert property (@(posedge clk) disable iff (rst)
        res_rdata[DATA_W-1:1] == '0);

    // R11: copies move only after a write
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(alias_we) && !$past(res_write && res_kind == 4'b1000))
        |-> $stable(alias_rdata));

endmodule

bind grp1_enable_gate grp1_enable_gate_chk #(
    .DATA_W (DATA_W),
    .ENC_W  (ENC_W),
    .EC_W   (EC_W)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_el           (req_el),
    .req_sysreg       (req_sysreg),
    .cfg_gic_present  (cfg_gic_present),
    .cfg_aa64_present (cfg_aa64_present),
    .cfg_el3_present  (cfg_el3_present),
    .ctl_el3_sre      (ctl_el3_sre),
    .alias_we         (alias_we),
    .alias_rdata      (alias_rdata),
    .res_valid        (res_valid),
    .res_write        (res_write),
    .res_kind         (res_kind),
    .res_trap_el      (res_trap_el),
    .res_ec           (res_ec),
    .res_rdata        (res_rdata)
);

// File: tb/test_grp1_enable_gate.sv
module test_grp1_enable_gate;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] ENC_OK = 16'hC667;
    localparam int N_RANDOM = 2500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        req_valid = 0, req_write = 0;
    logic [1:0]  req_el = 0;
    logic [15:0] req_sysreg = 0;
    logic [63:0] req_wdata = 0;
    logic gic = 0, aa64 = 0, el3p = 0, el2e = 0, fgtp = 0;
    logic dprio = 0, dund = 0, irqr = 0, fgten = 0, ns = 0;
    logic sre1 = 0, sre2 = 0, sre3 = 0, frd = 0, fwr = 0, tall = 0, imo = 0;
    logic        alias_we = 0;
    logic [1:0]  alias_wdata = 0;
    logic [1:0]  alias_rdata;
    logic        res_valid, res_write;
    logic [3:0]  res_kind;
    logic [1:0]  res_trap_el, res_bank;
    logic [5:0]  res_ec;
    logic [63:0] res_rdata;

    grp1_enable_gate i_grp1_enable_gate (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_el(req_el),
        .req_sysreg(req_sysreg), .req_wdata(req_wdata),
        .cfg_gic_present(gic), .cfg_aa64_present(aa64), .cfg_el3_present(el3p),
        .cfg_el2_enabled(el2e), .cfg_fgt_present(fgtp),
        .ctl_dbg_undef_prio(dprio), .ctl_dbg_undef(dund), .ctl_el3_irq_route(irqr),
        .ctl_el3_fgt_en(fgten), .ctl_el3_ns(ns),
        .ctl_el1_sre(sre1), .ctl_el2_sre(sre2), .ctl_el3_sre(sre3),
        .ctl_fgt_rd_trap(frd), .ctl_fgt_wr_trap(fwr), .ctl_trap_all_g1(tall),
        .ctl_hyp_irq_override(imo),
        .alias_we(alias_we), .alias_wdata(alias_wdata), .alias_rdata(alias_rdata),
        .res_valid(res_valid), .res_write(res_write), .res_kind(res_kind),
        .res_trap_el(res_trap_el), .res_ec(res_ec), .res_bank(res_bank),
        .res_rdata(res_rdata)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference copies: secure, non-secure, unbanked
    logic m_sec = 0, m_nsec = 0, m_solo = 0;
    int   e_kind, e_tel, e_bank;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string chain_tag();
        if (!(req_valid && req_sysreg == ENC_OK)) return "R1";
        if (!gic || !aa64 || req_el == 2'd0)      return "R2";
        if (req_el == 2'd1)                        return "R3";
        if (req_el == 2'd2)                        return "R4";
        return "R5";
    endfunction

    function automatic void set_trap(int lvl);
        e_kind = 2;
        e_tel  = lvl;
    endfunction

    // Priority order taken from the requirements
    function automatic void predict();
        e_kind = 0; e_tel = 0; e_bank = 0;
        if (!(req_valid && req_sysreg == ENC_OK)) return;
        if (!gic || !aa64 || req_el == 2'd0) begin
            e_kind = 1;
        end else if (req_el == 2'd1) begin
            if (el3p && dprio && irqr)                                           e_kind = 1;
            else if (!sre1)                                                      set_trap(1);
            else if (el2e && fgtp && (!el3p || fgten) && (req_write ? fwr : frd)) set_trap(2);
            else if (el2e && tall)                                               set_trap(2);
            else if (el2e && imo)                                                e_kind = 4;
            else if (el3p && irqr) begin
                if (dund) e_kind = 1; else set_trap(3);
            end else                                                             e_kind = 8;
        end else if (req_el == 2'd2) begin
            if (el3p && dprio && irqr) e_kind = 1;
            else if (!sre2)            set_trap(2);
            else if (el3p && irqr) begin
                if (dund) e_kind = 1; else set_trap(3);
            end else                   e_kind = 8;
        end else begin
            if (!el3p)      e_kind = 1;
            else if (!sre3) set_trap(3);
            else            e_kind = 8;
        end
        if (e_kind == 8) e_bank = !el3p ? 0 : (ns ? 2 : 1);
    endfunction

    function automatic logic model_bit(int b);
        if (b == 1) return m_sec;
        if (b == 2) return m_nsec;
        return m_solo;
    endfunction

    // Inputs are set at a negedge before the call
    task automatic apply(input logic aw, input logic [1:0] awd);
        string t;
        logic [63:0] exp_rd;
        predict();
        t = chain_tag();
        @(posedge clk); @(negedge clk);
        check({t, " valid"}, 64'(res_valid), 64'(e_kind != 0));
        check({t, " kind"}, 64'(res_kind), 64'(e_kind));
        check("R6 trap level", 64'(res_trap_el), 64'(e_tel));
        check("R6 class", 64'(res_ec), (e_kind == 2) ? 64'h18 : 64'h0);
        check("R7 copy select", 64'(res_bank), 64'(e_bank));
        exp_rd = (e_kind == 8 && !req_write) ? 64'(model_bit(e_bank)) : 64'h0;
        check("R8 read data", res_rdata, exp_rd);
        req_valid   = 1'b0;
        alias_we    = aw;
        alias_wdata = awd;
        if (aw) begin
            m_sec  = awd[0];
            m_nsec = awd[1];
        end
        if (e_kind == 8 && req_write) begin
            case (e_bank)
                1:       m_sec  = req_wdata[0];
                2:       m_nsec = req_wdata[0];
                default: m_solo = req_wdata[0];
            endcase
        end
        @(posedge clk); @(negedge clk);
        alias_we = 1'b0;
        check((aw || (e_kind == 8 && req_write)) ? "R10 alias view" : "R11 copies held",
              64'(alias_rdata), {62'h0, m_nsec, m_sec});
    endtask

    task automatic all_pass();
        gic = 1; aa64 = 1; el3p = 1; el2e = 1; fgtp = 1;
        dprio = 0; dund = 0; irqr = 0; fgten = 1; ns = 0;
        sre1 = 1; sre2 = 1; sre3 = 1; frd = 0; fwr = 0; tall = 0; imo = 0;
    endtask

    task automatic request(input logic wr, input logic [1:0] el, input logic [63:0] wd);
        req_valid  = 1'b1;
        req_write  = wr;
        req_el     = el;
        req_sysreg = ENC_OK;
        req_wdata  = wd;
    endtask

    function automatic logic bias(int num, int den);
        return ($urandom % den) < num;
    endfunction

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset clears the copies
        check("R9 reset alias view", 64'(alias_rdata), 64'h0);
        check("R9 reset no verdict", 64'(res_valid), 64'h0);

        // R9: unbanked copy reads 0 after reset
        all_pass(); el3p = 0;
        request(1'b0, 2'd1, 64'h0);
        apply(1'b0, 2'b00);

        // R8: upper write bits ignored, only bit 0 stored (Non-secure at EL3)
        all_pass(); ns = 1;
        request(1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFE);
        apply(1'b0, 2'b00);
        request(1'b1, 2'd3, 64'h0000_0000_0000_0001);
        apply(1'b0, 2'b00);
        request(1'b0, 2'd3, 64'h0);
        apply(1'b0, 2'b00);

        // R10: alias write, then read through the Secure bank at EL1
        all_pass(); el2e = 0;
        request(1'b0, 2'd2, 64'h0);
        apply(1'b1, 2'b01);
        request(1'b0, 2'd1, 64'h0);
        apply(1'b0, 2'b00);

        // R10: collision on one edge, access write to Secure wins
        all_pass();
        request(1'b1, 2'd3, 64'h0);
        apply(1'b1, 2'b11);

        // R5: EL3 request without EL3
        all_pass(); el3p = 0;
        request(1'b0, 2'd3, 64'h0);
        apply(1'b0, 2'b00);

        // R1: foreign encoding
        all_pass();
        request(1'b1, 2'd3, 64'h1);
        req_sysreg = ENC_OK ^ 16'h0001;
        apply(1'b0, 2'b00);

        // R3: fine-grained write trap not hit by a read
        all_pass(); fwr = 1; imo = 1;
        request(1'b0, 2'd1, 64'h0);
        apply(1'b0, 2'b00);
        request(1'b1, 2'd1, 64'h1);
        apply(1'b0, 2'b00);

        // Constrained random sweep
        for (int i = 0; i < N_RANDOM; i++) begin
            gic   = bias(15, 16);  aa64 = bias(15, 16);
            el3p  = bias(3, 4);    el2e = bias(1, 2);   fgtp = bias(1, 2);
            dprio = bias(1, 4);    dund = bias(1, 2);   irqr = bias(1, 4);
            fgten = bias(1, 2);    ns   = bias(1, 2);
            sre1  = bias(7, 8);    sre2 = bias(7, 8);   sre3 = bias(7, 8);
            frd   = bias(1, 4);    fwr  = bias(1, 4);   tall = bias(1, 6);
            imo   = bias(1, 4);
            request(bias(1, 2), 2'($urandom % 4), {$urandom, $urandom});
            if (bias(1, 16)) req_sysreg = ENC_OK ^ 16'(1 << ($urandom % 16));
            apply(bias(1, 6), 2'($urandom % 4));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule